// File: doc/BRIEF.md
# Word Stack Engine over a Byte Port

This block keeps a 16-bit stack pointer and moves whole 16-bit words onto and off a stack that lives in byte-wide memory. A caller raises a push request with a data word, or a pop request, and the engine performs two back-to-back byte cycles on the memory port. During those two cycles it reports busy. The pointer changes only after the second byte has been moved.

Every physical byte address is built from a 16-bit segment input, shifted left by four bits, plus a 16-bit offset taken from the stack pointer. The sum is kept to 20 bits. A push stores the upper byte below the pointer and then the lower byte beneath that. A pop reads the lower byte at the pointer and then the upper byte just above it, so the stack grows downward and behaves last-in first-out. A pop whose destination is the code segment register is refused. A push and a pop requested in the same cycle are also refused. Both cases raise a one-cycle illegal flag and leave the pointer and memory untouched.

Top module: `stk_word_engine`

## Requirements
- R1: An accepted push writes the upper data byte (bits 15:8) on the first cycle after acceptance, at offset SP-1.
- R2: On the second cycle a push writes the lower byte (bits 7:0) at offset SP-2, and after that cycle SP has decreased by 2.
- R3: An accepted pop reads offset SP on the first cycle and SP+1 on the second. After the second cycle SP has increased by 2, pop_valid pulses for one cycle, and pop_data holds {byte from SP+1, byte from SP}.
- R4: mem_addr equals (seg_base × 16 + offset) modulo 2^20, where the offset is 16 bits wide.
- R5: A pop requested with pop_to_cs high (and no push) is rejected. illegal pulses on the next cycle, no memory cycle occurs, and SP is unchanged.
- R6: push_req and pop_req high in the same idle cycle raise illegal on the next cycle, start no memory cycle and leave SP unchanged.
- R7: Requests that arrive while busy is high are ignored, and no further operation follows them.
- R8: SP arithmetic wraps modulo 65536.
- R9: After reset, SP equals the RESET_SP parameter (default 0x0000), busy, illegal and pop_valid are low, and no write or read enable is asserted.
- R10: Words pushed in the order A, B, C come back from three pops as C, B, A.
- R11: Each accepted operation holds busy for exactly two cycles and performs exactly one byte access in each of them. Read and write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop a word |
| push_data | input | 16 | Word to push, sampled on acceptance |
| pop_to_cs | input | 1 | Pop destination is the code segment register |
| seg_base | input | 16 | Stack segment value |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Byte write enable |
| mem_re | output | 1 | Byte read enable |
| mem_rdata | input | 8 | Byte read back, valid in the same cycle as mem_re |
| pop_data | output | 16 | Last popped word |
| pop_valid | output | 1 | One-cycle pulse when pop_data updates |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | One-cycle pulse for a rejected request |
| sp_value | output | 16 | Current stack pointer |

## Verification
The assertions watch the cycle-level rules on every cycle. Busy lasts two cycles and carries one access per cycle. Idle cycles carry no memory enable. The pointer moves by exactly two when an operation ends, and a rejected request neither starts work nor moves the pointer. Byte order, exact addresses including the 20-bit and 16-bit wraps, the data assembled by a pop and last-in first-out order depend on stored contents across whole operations. The bench's push and pop sweeps over several segment values are what show those.

// File: rtl/stk_pkg.sv
package stk_pkg;

    parameter int SP_W      = 16;
    parameter int SEG_SHIFT = 4;
    parameter int ADDR_W    = 20;
    parameter int BYTE_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI
    } stk_state_e;

    typedef enum logic [1:0] {
        OFS_ZERO,
        OFS_PLUS1,
        OFS_MINUS1,
        OFS_MINUS2
    } ofs_sel_e;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_DEC2,
        STEP_INC2
    } sp_step_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        logic     hi_byte;
        ofs_sel_e ofs;
    } byte_op_t;

    function automatic logic [ADDR_W-1:0] phys_addr(
        input logic [SP_W-1:0] seg,
        input logic [SP_W-1:0] ofs
    );
        logic [ADDR_W-1:0] base;
        base = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
        return base + ADDR_W'(ofs);
    endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push_req,
    input  logic     pop_req,
    input  logic     pop_to_cs,
    output byte_op_t op,
    output sp_step_e step,
    output logic     accept_push,
    output logic     latch_lo,
    output logic     finish_pop,
    output logic     busy,
    output logic     illegal
);

    stk_state_e state_q, state_d;
    logic       reject;

    always_comb begin
        state_d     = state_q;
        op          = '{wr: 1'b0, rd: 1'b0, hi_byte: 1'b0, ofs: OFS_ZERO};
        step        = STEP_NONE;
        accept_push = 1'b0;
        latch_lo    = 1'b0;
        finish_pop  = 1'b0;
        reject      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (push_req && pop_req) begin
                    reject = 1'b1;
                end else if (push_req) begin
                    accept_push = 1'b1;
                    state_d     = ST_PUSH_HI;
                end else if (pop_req) begin
                    if (pop_to_cs) reject = 1'b1;
                    else           state_d = ST_POP_LO;
                end
            end
            ST_PUSH_HI: begin
                op      = '{wr: 1'b1, rd: 1'b0, hi_byte: 1'b1, ofs: OFS_MINUS1};
                state_d = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                op      = '{wr: 1'b1, rd: 1'b0, hi_byte: 1'b0, ofs: OFS_MINUS2};
                step    = STEP_DEC2;
                state_d = ST_IDLE;
            end
            ST_POP_LO: begin
                op       = '{wr: 1'b0, rd: 1'b1, hi_byte: 1'b0, ofs: OFS_ZERO};
                latch_lo = 1'b1;
                state_d  = ST_POP_HI;
            end
            ST_POP_HI: begin
                op         = '{wr: 1'b0, rd: 1'b1, hi_byte: 1'b1, ofs: OFS_PLUS1};
                step       = STEP_INC2;
                finish_pop = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            illegal <= 1'b0;
        end else begin
            state_q <= state_d;
            illegal <= reject;
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R11: each transfer runs its two byte phases in order, then returns to idle
    p_push_phases_r11: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PUSH_HI |=> state_q == ST_PUSH_LO);
    p_pop_phases_r11: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_POP_LO |=> state_q == ST_POP_HI);
    p_end_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PUSH_LO || state_q == ST_POP_HI) |=> state_q == ST_IDLE);
    // R5/R6: a rejected request starts nothing
    p_reject_stays_idle_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> state_q == ST_IDLE);

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int                P_SP_W   = SP_W,
    parameter int                P_ADDR_W = ADDR_W,
    parameter logic [P_SP_W-1:0] RESET_SP = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  sp_step_e            step,
    input  ofs_sel_e            ofs_sel,
    input  logic [P_SP_W-1:0]   seg,
    output logic [P_SP_W-1:0]   sp,
    output logic [P_ADDR_W-1:0] addr
);

    localparam logic [P_SP_W-1:0] WORD_BYTES = P_SP_W'(2);

    logic [P_SP_W-1:0] sp_q;
    logic [P_SP_W-1:0] ofs_add;
    logic [P_SP_W-1:0] offset;

    always_comb begin
        unique case (ofs_sel)
            OFS_ZERO:   ofs_add = '0;
            OFS_PLUS1:  ofs_add = P_SP_W'(1);
            OFS_MINUS1: ofs_add = '1;
            OFS_MINUS2: ofs_add = ~P_SP_W'(1);
            default:    ofs_add = '0;
        endcase
    end

    assign offset = sp_q + ofs_add;
    assign addr   = P_ADDR_W'(phys_addr(SP_W'(seg), SP_W'(offset)));
    assign sp     = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= RESET_SP;
        end else begin
            unique case (step)
                STEP_DEC2: sp_q <= sp_q - WORD_BYTES;
                STEP_INC2: sp_q <= sp_q + WORD_BYTES;
                default:   sp_q <= sp_q;
            endcase
        end
    end

    // R8: the pointer only ever moves by one word, modulo 2^16
    p_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp_q) |-> (sp_q == $past(sp_q) + WORD_BYTES) || (sp_q == $past(sp_q) - WORD_BYTES));

endmodule

// File: rtl/stk_pop_asm.sv
module stk_pop_asm
    import stk_pkg::*;
#(
    parameter int P_BYTE_W = BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  latch_lo,
    input  logic                  finish_pop,
    input  logic [P_BYTE_W-1:0]   rdata,
    output logic [2*P_BYTE_W-1:0] word,
    output logic                  valid
);

    logic [P_BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= finish_pop;
            if (latch_lo)   lo_q <= rdata;
            if (finish_pop) word <= {rdata, lo_q};
        end
    end

    // R3: the finished word changes only when it is announced
    p_word_only_on_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(word));

endmodule

// File: rtl/stk_word_engine.sv
module stk_word_engine
    import stk_pkg::*;
#(
    parameter logic [15:0] RESET_SP = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic [15:0] push_data,
    input  logic        pop_to_cs,
    input  logic [15:0] seg_base,
    output logic [19:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pop_data,
    output logic        pop_valid,
    output logic        busy,
    output logic        illegal,
    output logic [15:0] sp_value
);

    localparam int WORD_W = 2 * BYTE_W;

    byte_op_t          op;
    sp_step_e          step;
    logic              accept_push;
    logic              latch_lo;
    logic              finish_pop;
    logic [WORD_W-1:0] push_q;

    stk_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .push_req    (push_req),
        .pop_req     (pop_req),
        .pop_to_cs   (pop_to_cs),
        .op          (op),
        .step        (step),
        .accept_push (accept_push),
        .latch_lo    (latch_lo),
        .finish_pop  (finish_pop),
        .busy        (busy),
        .illegal     (illegal)
    );

    stk_ptr #(
        .P_SP_W   (SP_W),
        .P_ADDR_W (ADDR_W),
        .RESET_SP (RESET_SP)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .ofs_sel (op.ofs),
        .seg     (seg_base),
        .sp      (sp_value),
        .addr    (mem_addr)
    );

    stk_pop_asm #(
        .P_BYTE_W (BYTE_W)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .latch_lo   (latch_lo),
        .finish_pop (finish_pop),
        .rdata      (mem_rdata),
        .word       (pop_data),
        .valid      (pop_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)              push_q <= '0;
        else if (accept_push) push_q <= push_data;
    end

    assign mem_we    = op.wr;
    assign mem_re    = op.rd;
    assign mem_wdata = op.hi_byte ? push_q[WORD_W-1:BYTE_W] : push_q[BYTE_W-1:0];

    // R11: at most one byte access per cycle
    p_one_access_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));
    // R7/R11: no memory traffic while idle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we && !mem_re);
    // R11: busy lasts exactly two cycles
    p_busy_two_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy && $fell(busy) == 1'b0);
    p_busy_ends_r11: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |=> !busy);
    // R2: completed push lowers the pointer by two
    p_sp_after_push_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && $past(mem_we) |-> sp_value == $past(sp_value) - 16'd2);
    // R3: completed pop raises the pointer by two and announces the word
    p_sp_after_pop_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && $past(mem_re) |-> sp_value == $past(sp_value) + 16'd2 && pop_valid);
    // R6: a rejected request leaves the pointer where it was
    p_illegal_keeps_sp_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy && $stable(sp_value));

endmodule

// File: tb/stk_word_engine_tb.sv
`timescale 1ns/1ps
module stk_word_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] push_data = '0;
    logic        pop_to_cs = 1'b0;
    logic [15:0] seg_base = '0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic [15:0] pop_data;
    logic        pop_valid;
    logic        busy;
    logic        illegal;
    logic [15:0] sp_value;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [15:0] sp_m;
    logic [7:0]  mem [0:4095];

    always #2.5 clk = ~clk;

    stk_word_engine #(.RESET_SP(16'h0000)) dut_i (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_to_cs(pop_to_cs), .seg_base(seg_base),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .pop_data(pop_data),
        .pop_valid(pop_valid), .busy(busy), .illegal(illegal), .sp_value(sp_value)
    );

    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return 20'((32'(s) * 16 + 32'(o)) % 32'h100000);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [15:0] d);
        logic [15:0] m1, m2;
        m1 = sp_m - 16'd1;
        m2 = sp_m - 16'd2;
        @(negedge clk); push_req = 1'b1; push_data = d;
        @(negedge clk); push_req = 1'b0; push_data = ~d;
        chk(busy && mem_we && !mem_re, "R11 first push cycle enables", {busy, mem_we, mem_re}, 3'b110);
        chk(mem_addr == pa(seg_base, m1), "R1/R4 push high address", mem_addr, pa(seg_base, m1));
        chk(mem_wdata == d[15:8], "R1 push high byte", mem_wdata, d[15:8]);
        @(negedge clk);
        chk(busy && mem_we, "R11 second push cycle", {busy, mem_we}, 2'b11);
        chk(mem_addr == pa(seg_base, m2), "R2/R4 push low address", mem_addr, pa(seg_base, m2));
        chk(mem_wdata == d[7:0], "R2 push low byte", mem_wdata, d[7:0]);
        @(negedge clk);
        sp_m = m2;
        chk(!busy && !mem_we, "R11 push done", {busy, mem_we}, 2'b00);
        chk(sp_value == sp_m, "R2/R8 sp after push", sp_value, sp_m);
    endtask

    task automatic do_pop(input logic [15:0] exp);
        logic [15:0] p1;
        p1 = sp_m + 16'd1;
        @(negedge clk); pop_req = 1'b1;
        @(negedge clk); pop_req = 1'b0;
        chk(busy && mem_re && !mem_we, "R11 first pop cycle enables", {busy, mem_re, mem_we}, 3'b110);
        chk(mem_addr == pa(seg_base, sp_m), "R3/R4 pop low address", mem_addr, pa(seg_base, sp_m));
        @(negedge clk);
        chk(mem_addr == pa(seg_base, p1), "R3/R4 pop high address", mem_addr, pa(seg_base, p1));
        @(negedge clk);
        sp_m = sp_m + 16'd2;
        chk(!busy && pop_valid, "R3 pop valid pulse", {busy, pop_valid}, 2'b01);
        chk(pop_data == exp, "R3/R10 popped word", pop_data, exp);
        chk(sp_value == sp_m, "R3/R8 sp after pop", sp_value, sp_m);
        @(negedge clk);
        chk(!pop_valid, "R3 valid one cycle", pop_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        sp_m = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(sp_value == 16'h0000, "R9 reset sp", sp_value, 0);
        chk(!busy && !illegal && !pop_valid, "R9 reset flags", {busy, illegal, pop_valid}, 0);
        chk(!mem_we && !mem_re, "R9 reset enables", {mem_we, mem_re}, 0);

        // R10 LIFO sweeps over several segments; start at SP=0 wraps (R8)
        foreach (seg_list[k]) begin
            seg_base = seg_list[k];
            for (int i = 0; i < 5; i++) do_push(16'((i + 1) * 16'h1357) ^ seg_list[k]);
            for (int i = 4; i >= 0; i--) do_pop(16'((i + 1) * 16'h1357) ^ seg_list[k]);
        end

        // R6 push and pop together
        seg_base = 16'h0200;
        @(negedge clk); push_req = 1'b1; pop_req = 1'b1; push_data = 16'hDEAD;
        @(negedge clk); push_req = 1'b0; pop_req = 1'b0;
        chk(illegal && !busy, "R6 simultaneous rejected", {illegal, busy}, 2'b10);
        chk(!mem_we && !mem_re, "R6 no access", {mem_we, mem_re}, 0);
        @(negedge clk);
        chk(!illegal && sp_value == sp_m, "R6 sp kept, pulse ends", {illegal, sp_value}, {1'b0, sp_m});

        // R5 pop into code segment register
        do_push(16'hA55A);
        @(negedge clk); pop_req = 1'b1; pop_to_cs = 1'b1;
        @(negedge clk); pop_req = 1'b0; pop_to_cs = 1'b0;
        chk(illegal && !busy && !mem_re, "R5 cs pop rejected", {illegal, busy, mem_re}, 3'b100);
        @(negedge clk);
        chk(sp_value == sp_m && !busy, "R5 sp unchanged", sp_value, sp_m);
        do_pop(16'hA55A);

        // R7 requests while busy are ignored
        @(negedge clk); push_req = 1'b1; push_data = 16'h7EC1;
        @(negedge clk); pop_req = 1'b1; push_data = 16'h0BAD;
        @(negedge clk); push_req = 1'b0; pop_req = 1'b0;
        @(negedge clk);
        sp_m = sp_m - 16'd2;
        chk(!busy && !illegal, "R7 no follow-on op", {busy, illegal}, 0);
        chk(sp_value == sp_m, "R7 single word pushed", sp_value, sp_m);
        @(negedge clk);
        chk(!busy && !mem_we && !mem_re, "R7 still idle", {busy, mem_we, mem_re}, 0);
        do_pop(16'h7EC1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    logic [15:0] seg_list [3] = '{16'h1000, 16'hFFFF, 16'h0123};

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule